// File: doc/BRIEF.md
# Bitplane-Ordered Programmable FIR Filter

This block is an unsigned FIR filter whose coefficients can be changed at run time. It is built as a grid of single-bit full-adder rows that work in carry-save form. Each row adds one partial product, which is the AND of a single coefficient bit with a delayed copy of the input word. The rows are ordered by bit weight. First the weight-0 products of every tap are added. Then the running sum is halved, and its lowest bit is retired as a finished result bit. Then the next weight is added, and so on up to the top coefficient bit. This order keeps the running word as narrow as the arithmetic allows.

A register slice follows every `PD` rows. To keep the weight ordering valid for any slice spacing, the sample fed to each row is taken from a shared input history at a depth of tap index plus slice number. The adder rows themselves are never rearranged. A short pipelined ripple adder, cut into chunks of `MW` bits, merges the final sum and carry words. The retired low bits are appended below the merged word.

New coefficients are written into a pending set. A commit strobe copies the pending set into the active set, and the active set then travels down the array in step with the data. Each slice therefore switches to the new set exactly when the first sample that must use it arrives.

Top module: `fir_bp_top`

## Requirements
- R1: For the sample x(n) captured at a rising edge, y_out gives the exact unsigned value sum over i = 0..NTAP-1 of c_i·x(n−i). Tap i is the product with the sample captured i edges earlier, and samples before reset count as zero.
- R2: The value for the sample captured at edge n is on y_out after edge n+LAT and stays there for one cycle. LAT = ceil(NTAP·CW/PD) + ceil(AW/MW), where AW = XW + clog2(NTAP) + 1. With the defaults, LAT is 13.
- R3: When cw_en is high at an edge and cw_tap = i < NTAP, cw_val is stored in pending slot i. Pending contents have no effect on y_out until a commit.
- R4: When c_commit is high at an edge, the pending set is copied into the active set, using the pending contents as they stood before any write at that same edge. The sample captured at that edge, and every later sample, uses only the new set. Every earlier sample is completed with the old set.
- R5: An active-low asynchronous reset clears y_out, the input history, the pending set and the active set to zero.
- R6: The slice spacing PD (1 or more) changes only the latency. The output values are the same for every PD.
- R7: With every coefficient at 2^CW−1 and a constant input of 2^XW−1, y_out settles at NTAP·(2^XW−1)·(2^CW−1) and no carry is lost inside the array or the merge adder.
- R8: A write with cw_tap ≥ NTAP changes nothing. A later commit loads the pending set as it was before that write.
- R9: Commits on consecutive edges each take effect exactly from the sample captured at their own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_in | input | XW | Unsigned input sample, captured every edge |
| cw_en | input | 1 | Write strobe for the pending coefficient set |
| cw_tap | input | clog2(NTAP) | Tap index to write |
| cw_val | input | CW | Unsigned coefficient value |
| c_commit | input | 1 | Copies the pending set into the active set |
| y_out | output | XW+CW+clog2(NTAP)+1 | Filtered output |

## Verification
A wrong coefficient bit, or a wrong history tap feeding one row, corrupts only the outputs of samples that pass that row with a nonzero partial product. Such an error shows as a wrong value LAT cycles after the offending sample. It persists for as long as the input pattern exercises that bit. A commit that switches one slice too early or too late shows only in the few outputs that straddle the commit, so those cycles are compared one by one against a convolution model. A lost carry or a mis-timed retired bit shows first under full-scale input. A latency that is off by one shows on a single impulse.

// File: rtl/fir_bp_pkg.sv
package fir_bp_pkg;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Running carry-save word width: input bits, tap growth, one guard bit.
    function automatic int acc_width(input int xw, input int ntap);
        return xw + $clog2(ntap) + 1;
    endfunction

endpackage

// File: rtl/fir_bp_coef.sv
module fir_bp_coef #(
    parameter int NTAP = 5,
    parameter int CW   = 4,
    parameter int NSTG = 10,
    parameter int TW   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cw_en,
    input  logic [TW-1:0]                    cw_tap,
    input  logic [CW-1:0]                    cw_val,
    input  logic                             c_commit,
    output logic [NSTG-1:0][NTAP*CW-1:0]     set_o
);

    logic [NTAP*CW-1:0] pend;
    logic               wr_ok;

    assign wr_ok = cw_en && (int'(cw_tap) < NTAP);

    // Pending set: written one tap at a time.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (wr_ok) begin
            pend[int'(cw_tap)*CW +: CW] <= cw_val;
        end
    end

    // Active set per slice: slice g sees the set that was active g edges earlier.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_o <= '0;
        end else begin
            for (int g = NSTG - 1; g > 0; g--) begin
                set_o[g] <= set_o[g-1];
            end
            if (c_commit) begin
                set_o[0] <= pend;
            end
        end
    end

    AST_SET_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !c_commit |=> $stable(set_o[0])) else $error("active set changed without commit"); // R4
    AST_BAD_TAP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (cw_en && int'(cw_tap) >= NTAP) |=> $stable(pend)) else $error("out-of-range write altered pending set"); // R8

endmodule

// File: rtl/fir_bp_array.sv
module fir_bp_array #(
    parameter int NTAP = 5,
    parameter int XW   = 6,
    parameter int CW   = 4,
    parameter int PD   = 2,
    parameter int AW   = 10,
    parameter int NSTG = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [XW-1:0]                 x_in,
    input  logic [NSTG-1:0][NTAP*CW-1:0]  set_i,
    output logic [AW-1:0]                 s_o,
    output logic [AW-1:0]                 c_o,
    output logic [CW-1:0]                 l_o
);

    localparam int NROW = NTAP * CW;
    localparam int HD   = NTAP + NSTG - 1;

    // Shared input history: hist[k] holds the sample captured k+1 edges ago.
    logic [XW-1:0] hist [HD];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < HD; k++) begin
                hist[k] <= '0;
            end
        end else begin
            hist[0] <= x_in;
            for (int k = 1; k < HD; k++) begin
                hist[k] <= hist[k-1];
            end
        end
    end

    logic [AW-1:0] rin_s  [NROW];
    logic [AW-1:0] rin_c  [NROW];
    logic [CW-1:0] rin_l  [NROW];
    logic [AW-1:0] rout_s [NROW];
    logic [AW-1:0] rout_c [NROW];
    logic [CW-1:0] rout_l [NROW];

    logic [AW-1:0] st_s [NSTG];
    logic [AW-1:0] st_c [NSTG];
    logic [CW-1:0] st_l [NSTG];

    // Row r handles weight J of tap I; rows are ordered weight-major.
    for (genvar r = 0; r < NROW; r++) begin : g_row
        localparam int J = r / NTAP;
        localparam int I = r % NTAP;
        localparam int G = r / PD;

        logic [AW-1:0] pp;
        logic [AW-1:0] fsum;
        logic [AW-1:0] fmaj;

        if (r == 0) begin : g_head
            assign rin_s[r] = '0;
            assign rin_c[r] = '0;
            assign rin_l[r] = '0;
        end else if (r % PD == 0) begin : g_slice
            assign rin_s[r] = st_s[G-1];
            assign rin_c[r] = st_c[G-1];
            assign rin_l[r] = st_l[G-1];
        end else begin : g_chain
            assign rin_s[r] = rout_s[r-1];
            assign rin_c[r] = rout_c[r-1];
            assign rin_l[r] = rout_l[r-1];
        end

        // Partial product: one coefficient bit gating the rescheduled sample.
        assign pp   = set_i[G][I*CW+J] ? {{(AW-XW){1'b0}}, hist[I+G]} : '0;
        assign fsum = rin_s[r] ^ rin_c[r] ^ pp;
        assign fmaj = (rin_s[r] & rin_c[r]) | (rin_s[r] & pp) | (rin_c[r] & pp);

        if (I == NTAP - 1) begin : g_plane_end
            // Weight finished: bit 0 is final, retire it and halve the word.
            assign rout_s[r] = {1'b0, fsum[AW-1:1]};
            assign rout_c[r] = {1'b0, fmaj[AW-2:0]};
            assign rout_l[r] = {fsum[0], rin_l[r][CW-1:1]};
        end else begin : g_plane_mid
            assign rout_s[r] = fsum;
            assign rout_c[r] = {fmaj[AW-2:0], 1'b0};
            assign rout_l[r] = rin_l[r];
        end

        AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n) fmaj[AW-1] == 1'b0) else $error("carry lost at top of row"); // R7
    end

    // Slice registers after every PD rows (and after the last row).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NSTG; g++) begin
                st_s[g] <= '0;
                st_c[g] <= '0;
                st_l[g] <= '0;
            end
        end else begin
            for (int g = 0; g < NSTG; g++) begin
                st_s[g] <= rout_s[(g*PD+PD-1 < NROW) ? g*PD+PD-1 : NROW-1];
                st_c[g] <= rout_c[(g*PD+PD-1 < NROW) ? g*PD+PD-1 : NROW-1];
                st_l[g] <= rout_l[(g*PD+PD-1 < NROW) ? g*PD+PD-1 : NROW-1];
            end
        end
    end

    assign s_o = st_s[NSTG-1];
    assign c_o = st_c[NSTG-1];
    assign l_o = st_l[NSTG-1];

endmodule

// File: rtl/fir_bp_merge.sv
module fir_bp_merge #(
    parameter int AW  = 10,
    parameter int CW  = 4,
    parameter int MW  = 4,
    parameter int NCH = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      s_i,
    input  logic [AW-1:0]      c_i,
    input  logic [CW-1:0]      l_i,
    output logic [AW+CW-1:0]   y_o
);

    localparam int PW = NCH * MW;

    logic [PW-1:0] a_in  [NCH];
    logic [PW-1:0] b_in  [NCH];
    logic [PW-1:0] r_in  [NCH];
    logic          cy_in [NCH];
    logic [CW-1:0] l_in  [NCH];
    logic [MW:0]   part  [NCH];

    logic [PW-1:0] a_q  [NCH];
    logic [PW-1:0] b_q  [NCH];
    logic [PW-1:0] r_q  [NCH];
    logic          cy_q [NCH];
    logic [CW-1:0] l_q  [NCH];

    // Stage k adds chunk k of both words plus the carry from stage k-1.
    always_comb begin
        a_in[0]          = '0;
        a_in[0][AW-1:0]  = s_i;
        b_in[0]          = '0;
        b_in[0][AW-1:0]  = c_i;
        r_in[0]          = '0;
        cy_in[0]         = 1'b0;
        l_in[0]          = l_i;
        for (int k = 1; k < NCH; k++) begin
            a_in[k]  = a_q[k-1];
            b_in[k]  = b_q[k-1];
            r_in[k]  = r_q[k-1];
            cy_in[k] = cy_q[k-1];
            l_in[k]  = l_q[k-1];
        end
        for (int k = 0; k < NCH; k++) begin
            part[k] = {1'b0, a_in[k][k*MW +: MW]} + {1'b0, b_in[k][k*MW +: MW]} + {{MW{1'b0}}, cy_in[k]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NCH; k++) begin
                a_q[k]  <= '0;
                b_q[k]  <= '0;
                r_q[k]  <= '0;
                cy_q[k] <= 1'b0;
                l_q[k]  <= '0;
            end
        end else begin
            for (int k = 0; k < NCH; k++) begin
                a_q[k]  <= a_in[k];
                b_q[k]  <= b_in[k];
                r_q[k]  <= r_in[k] | (PW'(part[k][MW-1:0]) << (k*MW));
                cy_q[k] <= part[k][MW];
                l_q[k]  <= l_in[k];
            end
        end
    end

    assign y_o = {r_q[NCH-1][AW-1:0], l_q[NCH-1]};

    logic unused_merge;
    assign unused_merge = ^{a_q[NCH-1], b_q[NCH-1], r_q[NCH-1]};

    AST_MERGE_FITS: assert property (@(posedge clk) disable iff (!rst_n) (!cy_q[NCH-1] && ((r_q[NCH-1] >> AW) == '0))) else $error("merged word exceeds output width"); // R7

endmodule

// File: rtl/fir_bp_top.sv
module fir_bp_top
    import fir_bp_pkg::*;
#(
    parameter int NTAP = 5,
    parameter int XW   = 6,
    parameter int CW   = 4,
    parameter int PD   = 2,
    parameter int MW   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [XW-1:0]                   x_in,
    input  logic                            cw_en,
    input  logic [$clog2(NTAP)-1:0]         cw_tap,
    input  logic [CW-1:0]                   cw_val,
    input  logic                            c_commit,
    output logic [XW+CW+$clog2(NTAP):0]     y_out
);

    localparam int TW   = $clog2(NTAP);
    localparam int AW   = acc_width(XW, NTAP);
    localparam int NROW = NTAP * CW;
    localparam int NSTG = ceil_div(NROW, PD);
    localparam int NCH  = ceil_div(AW, MW);

    logic [NSTG-1:0][NTAP*CW-1:0] sets;
    logic [AW-1:0]                arr_s;
    logic [AW-1:0]                arr_c;
    logic [CW-1:0]                arr_l;

    fir_bp_coef #(
        .NTAP (NTAP),
        .CW   (CW),
        .NSTG (NSTG),
        .TW   (TW)
    ) u_coef (
        .clk      (clk),
        .rst_n    (rst_n),
        .cw_en    (cw_en),
        .cw_tap   (cw_tap),
        .cw_val   (cw_val),
        .c_commit (c_commit),
        .set_o    (sets)
    );

    fir_bp_array #(
        .NTAP (NTAP),
        .XW   (XW),
        .CW   (CW),
        .PD   (PD),
        .AW   (AW),
        .NSTG (NSTG)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .x_in  (x_in),
        .set_i (sets),
        .s_o   (arr_s),
        .c_o   (arr_c),
        .l_o   (arr_l)
    );

    fir_bp_merge #(
        .AW  (AW),
        .CW  (CW),
        .MW  (MW),
        .NCH (NCH)
    ) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .s_i   (arr_s),
        .c_i   (arr_c),
        .l_i   (arr_l),
        .y_o   (y_out)
    );

endmodule

// File: tb/sim_fir_bp_top.sv
module sim_fir_bp_top;

    localparam int NTAP = 5;
    localparam int XW   = 6;
    localparam int CW   = 4;
    localparam int MW   = 4;
    localparam int TW   = 3;
    localparam int YW   = 14;
    localparam int ACCW = XW + TW + 1;
    localparam int LAT0 = (NTAP*CW + 1) / 2 + (ACCW + MW - 1) / MW;
    localparam int LAT1 = (NTAP*CW + 2) / 3 + (ACCW + MW - 1) / MW;
    localparam int MAXS = 512;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n = 1'b0;
    logic [XW-1:0]   x_in = '0;
    logic            cw_en = 1'b0;
    logic [TW-1:0]   cw_tap = '0;
    logic [CW-1:0]   cw_val = '0;
    logic            c_commit = 1'b0;
    logic [YW-1:0]   y0;
    logic [YW-1:0]   y1;

    fir_bp_top #(.NTAP(NTAP), .XW(XW), .CW(CW), .PD(2), .MW(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .cw_en(cw_en), .cw_tap(cw_tap),
        .cw_val(cw_val), .c_commit(c_commit), .y_out(y0)
    );

    fir_bp_top #(.NTAP(NTAP), .XW(XW), .CW(CW), .PD(3), .MW(MW)) u1 (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .cw_en(cw_en), .cw_tap(cw_tap),
        .cw_val(cw_val), .c_commit(c_commit), .y_out(y1)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R5";

    logic [XW-1:0] xs  [MAXS];
    logic [CW-1:0] csm [MAXS][NTAP];
    logic [CW-1:0] shm [NTAP];
    logic [CW-1:0] actm[NTAP];
    int            ns = 0;

    // Fields: [14] commit, [13] write, [12:10] tap, [9:6] value, [5:0] sample
    function automatic logic [14:0] mk(input bit com, input bit en, input int tap, input int val, input int x);
        return {com, en, 3'(tap), 4'(val), 6'(x)};
    endfunction

    localparam logic [14:0] VEC [0:19] = '{
        mk(0,1,0,3,5),  mk(0,1,1,1,9),  mk(0,1,2,4,2),  mk(0,1,3,1,63),
        mk(0,1,4,5,0),  mk(1,0,0,0,7),  mk(0,0,0,0,11), mk(0,0,0,0,40),
        mk(0,0,0,0,1),  mk(0,0,0,0,33), mk(0,0,0,0,62), mk(0,0,0,0,8),
        mk(0,0,0,0,19), mk(0,0,0,0,50), mk(0,1,2,15,27), mk(0,0,0,0,3),
        mk(1,0,0,0,44), mk(0,0,0,0,60), mk(0,0,0,0,0),  mk(0,0,0,0,13)
    };

    // Direct-form convolution model
    function automatic int expect_at(input int k);
        int acc = 0;
        if (k < 0) return 0;
        for (int i = 0; i < NTAP; i++) begin
            if (k - i >= 0) acc += int'(csm[k][i]) * int'(xs[k-i]);
        end
        return acc;
    endfunction

    task automatic check(input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic step(input logic [XW-1:0] x, input logic en, input logic [TW-1:0] tap,
                        input logic [CW-1:0] val, input logic com);
        x_in = x; cw_en = en; cw_tap = tap; cw_val = val; c_commit = com;
        @(posedge clk);
        if (com) for (int i = 0; i < NTAP; i++) actm[i] = shm[i];
        if (en && int'(tap) < NTAP) shm[tap] = val;
        if (ns < MAXS) begin
            xs[ns] = x;
            for (int i = 0; i < NTAP; i++) csm[ns][i] = actm[i];
        end
        ns++;
        @(negedge clk);
        check({tag, " u0"}, int'(y0), expect_at(ns - 1 - LAT0));
        check({tag, " u1 R6"}, int'(y1), expect_at(ns - 1 - LAT1));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(6'((i*13 + 5) % 64), 1'b0, '0, '0, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        x_in = '0; cw_en = 1'b0; cw_tap = '0; cw_val = '0; c_commit = 1'b0;
        repeat (2) @(negedge clk);
        check("R5 reset u0", int'(y0), 0);
        check("R5 reset u1", int'(y1), 0);
        for (int i = 0; i < NTAP; i++) begin
            shm[i] = '0;
            actm[i] = '0;
        end
        ns = 0;
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int first0;
        int first1;

        tag = "R5";
        do_reset();

        // Table walk: load a set, commit, stream, pend a change, commit again
        tag = "R1";
        for (int v = 0; v < 20; v++) begin
            step(VEC[v][5:0], VEC[v][13], VEC[v][12:10], VEC[v][9:6], VEC[v][14]);
        end
        idle(16);

        // Pending write without commit leaves outputs on the old set
        tag = "R3";
        step(6'd21, 1'b1, 3'd0, 4'd9, 1'b0);
        idle(20);

        // Commit switches exactly at its own sample
        tag = "R4";
        step(6'd9, 1'b0, 3'd0, 4'd0, 1'b1);
        idle(16);

        // Writes to taps beyond the last are dropped
        tag = "R8";
        step(6'd30, 1'b1, 3'd6, 4'd15, 1'b0);
        step(6'd31, 1'b1, 3'd7, 4'd15, 1'b1);
        idle(16);

        // Commits on consecutive edges
        tag = "R9";
        step(6'd12, 1'b1, 3'd1, 4'd2, 1'b0);
        step(6'd40, 1'b1, 3'd1, 4'd7, 1'b1);
        step(6'd41, 1'b0, 3'd0, 4'd0, 1'b1);
        step(6'd42, 1'b1, 3'd3, 4'd0, 1'b1);
        step(6'd43, 1'b0, 3'd0, 4'd0, 1'b1);
        idle(18);

        // Full scale
        tag = "R7";
        for (int t = 0; t < NTAP; t++) step(6'd63, 1'b1, 3'(t), 4'd15, 1'b0);
        step(6'd63, 1'b0, 3'd0, 4'd0, 1'b1);
        for (int t = 0; t < 28; t++) step(6'd63, 1'b0, 3'd0, 4'd0, 1'b0);
        check("R7 full-scale u0", int'(y0), NTAP * 63 * 15);
        check("R7 full-scale u1", int'(y1), NTAP * 63 * 15);

        // Reset clears the active set: nonzero input, zero output
        tag = "R5";
        do_reset();
        for (int t = 0; t < 20; t++) step(6'd63, 1'b0, 3'd0, 4'd0, 1'b0);
        check("R5 cleared set u0", int'(y0), 0);

        // Impulse through tap 0 measures the latency
        tag = "R2";
        step(6'd0, 1'b1, 3'd0, 4'd1, 1'b0);
        step(6'd0, 1'b0, 3'd0, 4'd0, 1'b1);
        for (int t = 0; t < 3; t++) step(6'd0, 1'b0, 3'd0, 4'd0, 1'b0);
        step(6'd1, 1'b0, 3'd0, 4'd0, 1'b0);
        first0 = -1;
        first1 = -1;
        for (int t = 1; t <= LAT0 + 2; t++) begin
            step(6'd0, 1'b0, 3'd0, 4'd0, 1'b0);
            if (first0 < 0 && y0 == YW'(1)) first0 = t;
            if (first1 < 0 && y1 == YW'(1)) first1 = t;
        end
        check("R2 latency u0", first0, LAT0);
        check("R2 latency u1 R6", first1, LAT1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule